// File: doc/BRIEF.md
# Asynchronous Memory Write Strobe Sequencer

This block carries out a single write to an external asynchronous memory or memory-mapped peripheral. A write is offered on a valid/ready request port. The request carries the address, the bank address, the write data and a per-byte lane mask. It also carries the timing for that write: a setup length, a strobe length, a hold length and an extended-wait count, all in controller clock cycles. It carries two mode bits as well: extended wait, and chip select following the strobe. Once the request is accepted, the block drives the memory bus and lowers the active-low write enable for the strobe phase. It then holds the bus for the hold phase and releases it.

In extended-wait mode the device can stretch the strobe by pulling its active-low wait line. The wait line passes through a two-flop synchroniser. The strobe ends a fixed four cycles after the synchronised wait is seen to deassert. If the device keeps the line low, the strobe is cut at the base strobe length plus sixteen times the extended-wait count, and a timeout pulse is raised. A done pulse marks the last cycle of each access.

Back-pressure: `req_ready` is high only while no access is in progress. A request is taken at the rising clock edge where `req_valid` and `req_ready` are both high. A requester that sees `req_ready` low keeps its request pending, and nothing it presents during an access has any effect.

Top module: `async_wr_seq`

## Requirements
- R1: `req_ready` is 1 exactly when no access is in progress. A request is taken only at an edge with `req_valid` and `req_ready` both 1, and `req_ready` stays 0 in every cycle of an access.
- R2: Outside an access, `mem_we_n` and `mem_cs_n` are 1, and `mem_dq_oe`, `acc_done` and `acc_timeout` are 0, including right after reset.
- R3: Starting in the cycle after the accepting edge, the bus is driven (`mem_dq_oe` = 1) with `mem_we_n` = 1 for exactly `req_setup` cycles. With a setup of 0, `mem_we_n` is 0 in the first cycle of the access.
- R4: Without extended wait, `mem_we_n` is 0 for exactly `req_strobe` consecutive cycles; a strobe of 0 is treated as 1. The wait input has no effect in this mode.
- R5: After `mem_we_n` returns to 1, the bus stays driven for exactly `req_hold` cycles (none when 0). `mem_dq_oe` is 0 in the cycle after that.
- R6: Throughout an access, `mem_addr`, `mem_bank`, `mem_wdata` and `mem_lane_mask` equal the accepted request's values and do not change. A mask bit of 1 means that byte lane is not written.
- R7: With extended wait on and `mem_wait_n` held 0 from before the access, suppose `mem_wait_n` is first sampled 1 at the edge that ends strobe cycle j (cycles numbered from 0). Then the strobe lasts min(L, max(S, j+6)) cycles, where S is the effective strobe length and L = S + 16·`req_ext_cnt`.
- R8: With extended wait on, if the synchronised wait is still asserted in strobe cycle L-1, the strobe ends there. In that case `acc_timeout` is 1 for exactly that one cycle, which is the last cycle with `mem_we_n` = 0. Otherwise `acc_timeout` stays 0.
- R9: With `req_sel_strobe` = 0, `mem_cs_n` is 0 in every cycle of the access. With `req_sel_strobe` = 1, `mem_cs_n` equals `mem_we_n` throughout the access.
- R10: `acc_done` is 1 for exactly one cycle per access, in its last cycle: the last hold cycle, or the last strobe cycle when the hold is 0. `req_ready` is 1 in the next cycle.
- R11: Timing fields, mode bits and payload are captured at the accepting edge. Changing the request inputs during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | 13 | Word address |
| req_bank | input | 2 | Bank address |
| req_wdata | input | 16 | Write data |
| req_lane_mask | input | 2 | Per-byte mask, 1 = lane not written |
| req_setup | input | 4 | Setup length in cycles |
| req_strobe | input | 6 | Strobe length in cycles (0 acts as 1) |
| req_hold | input | 3 | Hold length in cycles |
| req_ext_cnt | input | 8 | Extended-wait limit in units of 16 cycles |
| req_ext_en | input | 1 | Enable device wait stretching |
| req_sel_strobe | input | 1 | Chip select follows the write enable |
| mem_wait_n | input | 1 | Device wait, active low, asynchronous |
| mem_addr | output | 13 | Address to memory |
| mem_bank | output | 2 | Bank address to memory |
| mem_wdata | output | 16 | Data to memory |
| mem_lane_mask | output | 2 | Byte lane mask to memory |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cs_n | output | 1 | Chip select, active low |
| acc_done | output | 1 | Last cycle of the access |
| acc_timeout | output | 1 | Extended wait cut by the limit |

## Verification
A wrong phase counter or state shows up at once as a setup, strobe or hold that is one or more cycles off. It is visible on `mem_we_n` and `mem_dq_oe` within the access where it occurs. A fault in the wait tracking or the release count appears as a strobe length that breaks the min/max rule of R7. It can also appear as a timeout pulse that is missing, misplaced or spurious, all within the stretched strobe. A stuck mode bit or payload register shows as a wrong chip-select pattern or wrong bus value in the first cycle of the next access.

// File: rtl/awseq_pkg.sv
package awseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } awseq_state_e;

  typedef struct packed {
    logic ext_en;
    logic sel_strobe;
  } awseq_mode_t;

endpackage

// File: rtl/awseq_sync.sv
module awseq_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d_async;
      stage2 <= stage1;
    end
  end

  assign q_sync = stage2;
endmodule

// File: rtl/awseq_hold_reg.sv
module awseq_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/awseq_phase_cnt.sv
module awseq_phase_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (dec && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/awseq_strobe_ctl.sv
module awseq_strobe_ctl #(
  parameter int WST_W    = 6,
  parameter int EWC_W    = 8,
  parameter int EXT_UNIT = 16,
  parameter int REL_DLY  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             ext_en,
  input  logic [WST_W-1:0] base_len,
  input  logic [EWC_W-1:0] ext_cnt,
  input  logic             wait_act,
  output logic             last,
  output logic             tmo
);
  localparam int MAX_LEN = (2**WST_W - 1) + EXT_UNIT * (2**EWC_W - 1);
  localparam int STB_W   = $clog2(MAX_LEN + 1);
  localparam int RW      = $clog2(REL_DLY) + 1;

  logic [STB_W-1:0] elapsed;
  logic [STB_W-1:0] base_ext;
  logic [STB_W-1:0] limit;
  logic             waiting;
  logic [RW-1:0]    rel_left;
  logic             base_met, at_cap, rel_busy, stretch;

  assign base_ext = STB_W'(base_len);
  assign limit    = ext_en ? (base_ext + STB_W'(EXT_UNIT) * STB_W'(ext_cnt)) : base_ext;
  assign base_met = (elapsed + STB_W'(1)) >= base_ext;
  assign at_cap   = (elapsed + STB_W'(1)) == limit;
  assign rel_busy = rel_left > RW'(1);
  assign stretch  = ext_en && (waiting || wait_act || rel_busy);

  assign last = active && (at_cap || (base_met && !stretch));
  assign tmo  = active && ext_en && at_cap && wait_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed  <= '0;
      waiting  <= 1'b0;
      rel_left <= '0;
    end else if (!active) begin
      elapsed  <= '0;
      waiting  <= 1'b0;
      rel_left <= '0;
    end else begin
      elapsed <= elapsed + 1'b1;
      if (ext_en) begin
        if (wait_act) begin
          waiting  <= 1'b1;
          rel_left <= '0;
        end else if (waiting) begin
          waiting  <= 1'b0;
          rel_left <= RW'(REL_DLY - 1);
        end else if (rel_left != '0) begin
          rel_left <= rel_left - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/async_wr_seq.sv
module async_wr_seq
  import awseq_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int BANK_W   = 2,
  parameter int DATA_W   = 16,
  parameter int WS_W     = 4,
  parameter int WST_W    = 6,
  parameter int WH_W     = 3,
  parameter int EWC_W    = 8,
  parameter int EXT_UNIT = 16,
  parameter int REL_DLY  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [BANK_W-1:0]   req_bank,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_lane_mask,
  input  logic [WS_W-1:0]     req_setup,
  input  logic [WST_W-1:0]    req_strobe,
  input  logic [WH_W-1:0]     req_hold,
  input  logic [EWC_W-1:0]    req_ext_cnt,
  input  logic                req_ext_en,
  input  logic                req_sel_strobe,
  input  logic                mem_wait_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [BANK_W-1:0]   mem_bank,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [DATA_W/8-1:0] mem_lane_mask,
  output logic                mem_dq_oe,
  output logic                mem_we_n,
  output logic                mem_cs_n,
  output logic                acc_done,
  output logic                acc_timeout
);
  localparam int LANES = DATA_W / 8;
  localparam int PAY_W = ADDR_W + BANK_W + DATA_W + LANES;
  localparam int CFG_W = WST_W + WH_W + EWC_W + $bits(awseq_mode_t);
  localparam int CW    = (WS_W > WH_W) ? WS_W : WH_W;

  awseq_state_e state_q, state_d;
  logic         accept;
  logic         ph_load, ph_dec, ph_zero;
  logic [CW-1:0] ph_val;
  logic         stb_active, stb_last, stb_tmo;
  logic         wait_sync_n;

  logic [WST_W-1:0] strobe_eff;
  logic [WST_W-1:0] wst_q;
  logic [WH_W-1:0]  wh_q;
  logic [EWC_W-1:0] ewc_q;
  awseq_mode_t      mode_in, mode_q;
  logic             ext_q, sel_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // Strobe length of zero acts as a single cycle
  assign strobe_eff = (req_strobe == '0) ? WST_W'(1) : req_strobe;
  assign mode_in    = '{ext_en: req_ext_en, sel_strobe: req_sel_strobe};

  awseq_hold_reg #(.W(PAY_W)) u_payload (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .d     ({req_addr, req_bank, req_wdata, req_lane_mask}),
    .q     ({mem_addr, mem_bank, mem_wdata, mem_lane_mask})
  );

  awseq_hold_reg #(.W(CFG_W)) u_config (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .d     ({strobe_eff, req_hold, req_ext_cnt, mode_in}),
    .q     ({wst_q, wh_q, ewc_q, mode_q})
  );

  assign ext_q = mode_q.ext_en;
  assign sel_q = mode_q.sel_strobe;

  awseq_sync #(.RST_VAL(1'b1)) u_wait_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (mem_wait_n),
    .q_sync  (wait_sync_n)
  );

  assign stb_active = (state_q == ST_STROBE);

  awseq_strobe_ctl #(
    .WST_W    (WST_W),
    .EWC_W    (EWC_W),
    .EXT_UNIT (EXT_UNIT),
    .REL_DLY  (REL_DLY)
  ) u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (stb_active),
    .ext_en   (ext_q),
    .base_len (wst_q),
    .ext_cnt  (ewc_q),
    .wait_act (!wait_sync_n),
    .last     (stb_last),
    .tmo      (stb_tmo)
  );

  // Phase counter for setup and hold: loaded with length-1
  always_comb begin
    ph_load = 1'b0;
    ph_val  = '0;
    if (accept && req_setup != '0) begin
      ph_load = 1'b1;
      ph_val  = CW'(req_setup) - 1'b1;
    end else if (stb_active && stb_last && wh_q != '0) begin
      ph_load = 1'b1;
      ph_val  = CW'(wh_q) - 1'b1;
    end
  end

  assign ph_dec = (state_q == ST_SETUP) || (state_q == ST_HOLD);

  awseq_phase_cnt #(.W(CW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_val (ph_val),
    .dec      (ph_dec),
    .zero     (ph_zero)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = (req_setup != '0) ? ST_SETUP : ST_STROBE;
      ST_SETUP:  if (ph_zero) state_d = ST_STROBE;
      ST_STROBE: if (stb_last) state_d = (wh_q != '0) ? ST_HOLD : ST_IDLE;
      ST_HOLD:   if (ph_zero) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign mem_dq_oe   = (state_q != ST_IDLE);
  assign mem_we_n    = !stb_active;
  assign mem_cs_n    = sel_q ? !stb_active : (state_q == ST_IDLE);
  assign acc_done    = ((state_q == ST_HOLD) && ph_zero) ||
                       (stb_active && stb_last && wh_q == '0);
  assign acc_timeout = stb_tmo;
endmodule

// File: rtl/awseq_chk.sv
module awseq_chk #(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_ready,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [BANK_W-1:0]   mem_bank,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic [DATA_W/8-1:0] mem_lane_mask,
  input logic                mem_dq_oe,
  input logic                mem_we_n,
  input logic                mem_cs_n,
  input logic                acc_done,
  input logic                acc_timeout,
  input logic                ext_q,
  input logic                sel_q
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_we_n && mem_cs_n && !mem_dq_oe && !acc_done && !acc_timeout)); // R2

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !req_ready); // R1

  AST_STROBE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe); // R3

  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |->
      ($stable(mem_addr) && $stable(mem_bank) && $stable(mem_wdata) && $stable(mem_lane_mask))); // R6

  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> req_ready); // R10

  AST_TMO_IN_EXT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_timeout |-> (ext_q && !mem_we_n)); // R8

  AST_TMO_ENDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_timeout |=> mem_we_n); // R8

  AST_SEL_FOLLOWS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && sel_q) |-> (mem_cs_n == mem_we_n)); // R9

  AST_CS_WHOLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && !sel_q) |-> !mem_cs_n); // R9
endmodule

bind async_wr_seq awseq_chk #(
  .ADDR_W (ADDR_W),
  .BANK_W (BANK_W),
  .DATA_W (DATA_W)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_addr      (mem_addr),
  .mem_bank      (mem_bank),
  .mem_wdata     (mem_wdata),
  .mem_lane_mask (mem_lane_mask),
  .mem_dq_oe     (mem_dq_oe),
  .mem_we_n      (mem_we_n),
  .mem_cs_n      (mem_cs_n),
  .acc_done      (acc_done),
  .acc_timeout   (acc_timeout),
  .ext_q         (ext_q),
  .sel_q         (sel_q)
);

// File: tb/test_async_wr_seq.sv
module test_async_wr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [12:0] req_addr = '0;
  logic [1:0]  req_bank = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_lane_mask = '0;
  logic [3:0]  req_setup = '0;
  logic [5:0]  req_strobe = '0;
  logic [2:0]  req_hold = '0;
  logic [7:0]  req_ext_cnt = '0;
  logic        req_ext_en = 1'b0;
  logic        req_sel_strobe = 1'b0;
  logic        mem_wait_n = 1'b1;
  logic [12:0] mem_addr;
  logic [1:0]  mem_bank;
  logic [15:0] mem_wdata;
  logic [1:0]  mem_lane_mask;
  logic        mem_dq_oe, mem_we_n, mem_cs_n, acc_done, acc_timeout;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  async_wr_seq i_async_wr_seq (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_strobe(input int wst);
    return (wst == 0) ? 1 : wst;
  endfunction

  function automatic int exp_strobe(input int wst, input int ewc, input bit ext, input int j);
    int s, lim, v;
    s = eff_strobe(wst);
    if (!ext || j < 0) return s;
    lim = s + 16 * ewc;
    v = (j + 6 > s) ? j + 6 : s;
    return (v > lim) ? lim : v;
  endfunction

  function automatic bit exp_tmo(input int wst, input int ewc, input bit ext, input int j);
    if (!ext || j < 0) return 1'b0;
    return (j + 2 >= eff_strobe(wst) + 16 * ewc);
  endfunction

  // j < 0: wait never asserted; otherwise wait low before the access and
  // released at the negedge of strobe cycle j
  task automatic run_acc(input int ws, input int wst, input int wh, input int ewc,
                         input bit ext, input bit sel, input int j);
    logic [12:0] a;
    logic [1:0]  b, m;
    logic [15:0] d;
    int setup_n, stb_n, hold_n, bus_bad, cs_bad, rdy_bad, done_n, done_c;
    int tmo_n, tmo_c, last_stb_c, last_c;
    bit seen_stb, after_stb;
    a = 13'($urandom); b = 2'($urandom); d = 16'($urandom); m = 2'($urandom);
    setup_n = 0; stb_n = 0; hold_n = 0; bus_bad = 0; cs_bad = 0; rdy_bad = 0;
    done_n = 0; done_c = -1; tmo_n = 0; tmo_c = -2; last_stb_c = -1; last_c = -1;
    seen_stb = 0; after_stb = 0;
    if (j >= 0) begin
      mem_wait_n = 1'b0;
      repeat (3) @(negedge clk);
    end
    req_addr = a; req_bank = b; req_wdata = d; req_lane_mask = m;
    req_setup = 4'(ws); req_strobe = 6'(wst); req_hold = 3'(wh); req_ext_cnt = 8'(ewc);
    req_ext_en = ext; req_sel_strobe = sel; req_valid = 1'b1;
    check(req_ready == 1'b1, "R1 ready while idle", int'(req_ready), 1);
    @(negedge clk);
    for (int c = 0; c < 6000; c++) begin
      if (!mem_dq_oe) break;
      last_c = c;
      if (req_ready) rdy_bad++;
      if (mem_addr != a || mem_bank != b || mem_wdata != d || mem_lane_mask != m) bus_bad++;
      if (sel ? (mem_cs_n != mem_we_n) : (mem_cs_n != 1'b0)) cs_bad++;
      if (!mem_we_n) begin
        if (stb_n == j) mem_wait_n = 1'b1;
        stb_n++; seen_stb = 1; last_stb_c = c;
        if (after_stb) bus_bad += 100;
      end else if (!seen_stb) setup_n++;
      else begin after_stb = 1; hold_n++; end
      if (acc_timeout) begin tmo_n++; tmo_c = c; end
      if (c == 0) begin
        req_addr = ~a; req_bank = ~b; req_wdata = ~d; req_lane_mask = ~m;
        req_setup = 4'(ws + 3); req_strobe = 6'(wst + 5); req_hold = 3'(wh + 1);
        req_ext_en = ~ext; req_sel_strobe = ~sel;
      end
      if (acc_done) begin done_n++; done_c = c; req_valid = 1'b0; end
      @(negedge clk);
    end
    req_valid = 1'b0;
    mem_wait_n = 1'b1;
    check(setup_n == ws, "R3 setup length", setup_n, ws);
    check(stb_n == exp_strobe(wst, ewc, ext, j), "R4/R7 strobe length", stb_n, exp_strobe(wst, ewc, ext, j));
    check(hold_n == wh, "R5 hold length", hold_n, wh);
    check(bus_bad == 0, "R6/R11 bus values held", bus_bad, 0);
    check(cs_bad == 0, "R9 chip select pattern", cs_bad, 0);
    check(rdy_bad == 0, "R1 not ready while busy", rdy_bad, 0);
    check(done_n == 1 && done_c == last_c, "R10 done pulse in last cycle", done_c, last_c);
    check(tmo_n == int'(exp_tmo(wst, ewc, ext, j)), "R8 timeout count", tmo_n, int'(exp_tmo(wst, ewc, ext, j)));
    if (exp_tmo(wst, ewc, ext, j))
      check(tmo_c == last_stb_c, "R8 timeout on last strobe cycle", tmo_c, last_stb_c);
    check(mem_we_n && mem_cs_n && !mem_dq_oe && req_ready && !acc_done && !acc_timeout,
          "R2 released after access", {mem_we_n, mem_cs_n, mem_dq_oe, req_ready}, 4'b1101);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(mem_we_n && mem_cs_n && !mem_dq_oe && !acc_done && !acc_timeout,
          "R2 outputs in reset", {mem_we_n, mem_cs_n, mem_dq_oe}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    // Directed corners
    run_acc(0, 1, 0, 0, 0, 0, -1);   // R3 zero setup, R10 done in strobe
    run_acc(2, 0, 1, 0, 0, 0, -1);   // R4 zero strobe acts as one
    run_acc(1, 2, 2, 1, 1, 0, 999);  // R8 timeout at 2+16
    run_acc(0, 2, 1, 2, 1, 0, 3);    // R7 release: 3+6 = 9
    run_acc(1, 4, 0, 0, 1, 0, 1);    // R7 release lands on cap, no timeout
    run_acc(2, 10, 1, 1, 1, 1, 0);   // R7 base length dominates
    run_acc(3, 4, 2, 0, 0, 1, -1);   // R9 select-strobe
    run_acc(1, 3, 1, 2, 0, 0, 999);  // R4 wait ignored when not extended
    run_acc(15, 63, 7, 0, 0, 0, -1); // R3 R5 maximum fields
    // Random mix
    for (int k = 0; k < 40; k++) begin
      int ws, wst, wh, ewc, jj;
      bit ext, sel;
      ws  = $urandom_range(0, 5);
      wst = $urandom_range(0, 8);
      wh  = $urandom_range(0, 4);
      ewc = $urandom_range(0, 2);
      ext = 1'($urandom);
      sel = 1'($urandom);
      jj  = $urandom_range(0, 3) == 0 ? -1 : int'($urandom_range(0, 40));
      run_acc(ws, wst, wh, ewc, ext, sel, jj);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule